// File: doc/BRIEF.md
# Partitioned SIMD Adder

This block is a 64-bit packed-integer adder that can be split into independent lanes at run time. A single pass adds one 64-bit pair, two 32-bit pairs, four 16-bit pairs or eight 8-bit pairs. A subtract flag turns every lane into a difference. All arithmetic wraps modulo the lane width. There is no saturation and no overflow trap.

Internally the datapath is a single 72-bit carry chain made of eight 9-bit slices. Each slice holds one data byte per operand plus one extra bit position below the byte. The operand bits placed in that extra position decide what happens to the carry arriving from the slice beneath:
- 00 blocks the carry.
- 01 lets the carry through unchanged.
- 11 forces a carry of one into the slice.

Lane boundaries are therefore written into the operands themselves, and the chain needs no separate carry multiplexers. The packed sum is registered, together with one carry-out bit per lane, and is valid on the clock edge after the inputs are presented.

Top module: `simd_part_adder`

## Requirements
- R1: A synchronous active-high `rst` clears `sum` and `lane_cout` to zero on the next rising clock edge.
- R2: The result for the inputs sampled at a rising edge appears on `sum` and `lane_cout` just after that edge and stays there until the following edge.
- R3: `lane_sel` picks the lane width: 00 gives eight 8-bit lanes, 01 gives four 16-bit lanes, 10 gives two 32-bit lanes and 11 gives one 64-bit lane. Lane i occupies bits [i*W +: W] of each operand and of `sum`.
- R4: With `sub_en` low, each lane of `sum` equals the lane of `op_a` plus the lane of `op_b`, modulo 2^W. No carry crosses into the next lane.
- R5: Inside a lane wider than 8 bits, a carry ripples across the internal byte boundaries (for example 0x00FF + 0x0001 gives 0x0100 in a 16-bit lane).
- R6: With `sub_en` high, each lane of `sum` equals the lane of `op_a` minus the lane of `op_b`, modulo 2^W.
- R7: `lane_cout` bit k, where k is the index of the top byte of a lane (k = (i+1)*W/8 - 1), carries that lane's carry-out. For an addition this is the unsigned carry. For a subtraction it is 1 exactly when the `op_a` lane is greater than or equal to the `op_b` lane, unsigned.
- R8: Every `lane_cout` bit that is not at the top byte of a lane reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand (subtrahend when `sub_en` is high) |
| lane_sel | input | 2 | Lane width select (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| sum | output | 64 | Registered packed result |
| lane_cout | output | 8 | Registered carry-out, one bit at the top byte of each lane |

## Verification
Two effects meet at every byte boundary in the same cycle: a carry must be blocked where a lane ends, and the subtraction's +1 must be injected into the next lane's lowest byte. Both come from the same extra bit position, so both can break together.

The bench provokes this by subtracting with all-ones and zero byte patterns, so that each lane produces a carry-out while its neighbour needs its injected +1. It judges the packed result lane by lane against values computed arithmetically, and checks the carry vector for the right bits at lane tops and zeros everywhere else.

An exhaustive sweep of byte pairs in 8-bit mode covers every carry and boundary combination. Patterned and pseudo-random operands cover the wider modes.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  // Lane width chosen by the lane_sel input
  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_size_e;

  // Operand-bit pair {a,b} placed in the extra position below each slice
  typedef enum logic [1:0] {
    GATE_CLIP = 2'b00,  // carry from below is blocked
    GATE_PASS = 2'b01,  // carry from below ripples through
    GATE_GEN  = 2'b11   // a carry of one is forced into the slice
  } gate_code_e;

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
  parameter int N_SLICES = 8,
  parameter int SEL_W    = 2
) (
  input  logic [SEL_W-1:0]    lane_sel,
  output logic [N_SLICES-1:0] lane_start,
  output logic [N_SLICES-1:0] lane_top
);

  // (slices per lane) - 1; a slice index ANDed with it gives the position inside the lane
  logic [N_SLICES-1:0] span_mask;

  always_comb begin
    span_mask = (N_SLICES'(1) << lane_sel) - N_SLICES'(1);
  end

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    localparam logic [N_SLICES-1:0] K_IDX  = N_SLICES'(k);
    localparam logic [N_SLICES-1:0] K_NEXT = N_SLICES'(k + 1);

    assign lane_start[k] = ((K_IDX & span_mask) == '0);
    assign lane_top[k]   = ((K_NEXT & span_mask) == '0);
  end

endmodule

// File: rtl/simd_slice_pack.sv
module simd_slice_pack
  import simd_add_pkg::*;
#(
  parameter  int SLICE_W  = 8,
  parameter  int N_SLICES = 8,
  localparam int DATA_W   = SLICE_W * N_SLICES,
  localparam int SEG_W    = SLICE_W + 1,
  localparam int EXT_W    = SEG_W * N_SLICES
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic                sub_en,
  input  logic [N_SLICES-1:0] lane_start,
  output logic [EXT_W-1:0]    ext_a,
  output logic [EXT_W-1:0]    ext_b
);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_seg
    gate_code_e gate;

    // Lane start: block the carry, or force +1 for two's-complement subtract.
    // Inside a lane: let the carry ripple.
    always_comb begin
      if (lane_start[k]) begin
        gate = sub_en ? GATE_GEN : GATE_CLIP;
      end else begin
        gate = GATE_PASS;
      end
    end

    assign ext_a[k*SEG_W] = gate[1];
    assign ext_b[k*SEG_W] = gate[0];

    assign ext_a[k*SEG_W+1 +: SLICE_W] = op_a[k*SLICE_W +: SLICE_W];
    assign ext_b[k*SEG_W+1 +: SLICE_W] = op_b[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub_en}};
  end

endmodule

// File: rtl/simd_slice_unpack.sv
module simd_slice_unpack #(
  parameter  int SLICE_W  = 8,
  parameter  int N_SLICES = 8,
  localparam int DATA_W   = SLICE_W * N_SLICES,
  localparam int SEG_W    = SLICE_W + 1,
  localparam int EXT_W    = SEG_W * N_SLICES
) (
  // Chain result shifted down by one: the lowest extra position is dropped
  // and the final carry sits at the top.
  input  logic [EXT_W-1:0]    ext_sum,
  input  logic [N_SLICES-1:0] lane_top,
  output logic [DATA_W-1:0]   sum,
  output logic [N_SLICES-1:0] lane_cout
);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_seg
    assign sum[k*SLICE_W +: SLICE_W] = ext_sum[k*SEG_W +: SLICE_W];

    // The extra position above a slice shows the carry leaving that slice
    assign lane_cout[k] = lane_top[k] & ext_sum[(k+1)*SEG_W-1];
  end

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_add_pkg::*;
#(
  parameter  int SLICE_W  = 8,
  parameter  int N_SLICES = 8,
  parameter  int SEL_W    = 2,
  localparam int DATA_W   = SLICE_W * N_SLICES,
  localparam int EXT_W    = (SLICE_W + 1) * N_SLICES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [SEL_W-1:0]    lane_sel,
  input  logic                sub_en,
  output logic [DATA_W-1:0]   sum,
  output logic [N_SLICES-1:0] lane_cout
);

  logic [N_SLICES-1:0] lane_start;
  logic [N_SLICES-1:0] lane_top;
  logic [EXT_W-1:0]    ext_a;
  logic [EXT_W-1:0]    ext_b;
  logic [EXT_W-1:0]    ext_sum;
  logic [DATA_W-1:0]   sum_d;
  logic [N_SLICES-1:0] cout_d;

  simd_lane_map #(
    .N_SLICES (N_SLICES),
    .SEL_W    (SEL_W)
  ) u_map (
    .lane_sel   (lane_sel),
    .lane_start (lane_start),
    .lane_top   (lane_top)
  );

  simd_slice_pack #(
    .SLICE_W  (SLICE_W),
    .N_SLICES (N_SLICES)
  ) u_pack (
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_en     (sub_en),
    .lane_start (lane_start),
    .ext_a      (ext_a),
    .ext_b      (ext_b)
  );

  // One uninterrupted chain, one bit wider than the operands for the final
  // carry, then shifted down to drop the lowest extra position.
  assign ext_sum = EXT_W'(({1'b0, ext_a} + {1'b0, ext_b}) >> 1);

  simd_slice_unpack #(
    .SLICE_W  (SLICE_W),
    .N_SLICES (N_SLICES)
  ) u_unpack (
    .ext_sum   (ext_sum),
    .lane_top  (lane_top),
    .sum       (sum_d),
    .lane_cout (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      lane_cout <= '0;
    end else begin
      sum       <= sum_d;
      lane_cout <= cout_d;
    end
  end

endmodule

// File: rtl/simd_part_adder_chk.sv
module simd_part_adder_chk #(
  parameter  int SLICE_W  = 8,
  parameter  int N_SLICES = 8,
  parameter  int SEL_W    = 2,
  localparam int DATA_W   = SLICE_W * N_SLICES
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   op_a,
  input logic [DATA_W-1:0]   op_b,
  input logic [SEL_W-1:0]    lane_sel,
  input logic                sub_en,
  input logic [DATA_W-1:0]   sum,
  input logic [N_SLICES-1:0] lane_cout
);

  // Lane-by-lane arithmetic model, packed as {carry vector, sum}
  function automatic logic [N_SLICES+DATA_W-1:0] lane_ref(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [SEL_W-1:0]  sel,
    input logic              sub
  );
    int                  spl;
    int                  lw;
    logic [DATA_W:0]     mask;
    logic [DATA_W:0]     av;
    logic [DATA_W:0]     bv;
    logic [DATA_W:0]     r;
    logic [DATA_W-1:0]   s;
    logic [N_SLICES-1:0] c;

    spl  = 1 << sel;
    lw   = spl * SLICE_W;
    mask = ((DATA_W+1)'(1) << lw) - (DATA_W+1)'(1);
    s    = '0;
    c    = '0;

    for (int l = 0; l < N_SLICES; l++) begin
      if (l * spl < N_SLICES) begin
        av = ({1'b0, a} >> (l * lw)) & mask;
        bv = ({1'b0, b} >> (l * lw)) & mask;
        if (sub) bv = ~bv & mask;
        r = av + bv + (DATA_W+1)'(sub);
        s = s | DATA_W'((r & mask) << (l * lw));
        c[(l+1)*spl-1] = r[lw];
      end
    end
    return {c, s};
  endfunction

  function automatic logic [N_SLICES-1:0] top_ref(input logic [SEL_W-1:0] sel);
    logic [N_SLICES-1:0] t;
    int                  spl;
    spl = 1 << sel;
    t   = '0;
    for (int k = 0; k < N_SLICES; k++) begin
      if (((k + 1) % spl) == 0) t[k] = 1'b1;
    end
    return t;
  endfunction

  logic [N_SLICES+DATA_W-1:0] ref_now;
  logic [N_SLICES-1:0]        top_now;

  assign ref_now = lane_ref(op_a, op_b, lane_sel, sub_en);
  assign top_now = top_ref(lane_sel);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum == '0 && lane_cout == '0));

  // R2 R3 R4 R5 R6
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum == $past(ref_now[DATA_W-1:0])));

  // R7
  cout_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lane_cout == $past(ref_now[N_SLICES+DATA_W-1:DATA_W])));

  // R8
  cout_place_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lane_cout & ~$past(top_now)) == '0));

endmodule

bind simd_part_adder simd_part_adder_chk #(
  .SLICE_W  (SLICE_W),
  .N_SLICES (N_SLICES),
  .SEL_W    (SEL_W)
) u_chk (.*);

// File: tb/test_simd_part_adder.sv
module test_simd_part_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  lane_sel = 2'b00;
  logic        sub_en = 1'b0;
  logic [63:0] sum;
  logic [7:0]  lane_cout;

  always #10 clk = ~clk;  // 50 MHz

  simd_part_adder i_simd_part_adder (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .lane_sel  (lane_sel),
    .sub_en    (sub_en),
    .sum       (sum),
    .lane_cout (lane_cout)
  );

  int          checks = 0;
  int          errors = 0;
  logic        pend = 1'b0;
  logic [63:0] exp_sum;
  logic [7:0]  exp_cout;
  logic [7:0]  exp_top;
  string       ptag;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  // Expected {carries, sum}: lane width 64 / (8 >> sel)
  function automatic logic [71:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] sel, input logic sub);
    int          nl;
    int          lw;
    int          bpl;
    logic [64:0] x;
    logic [64:0] y;
    logic [64:0] r;
    logic [64:0] m;
    logic [63:0] s;
    logic [7:0]  c;
    nl  = 8 >> sel;
    lw  = 64 / nl;
    bpl = 8 / nl;
    m   = (65'd1 << lw) - 65'd1;
    s   = '0;
    c   = '0;
    for (int l = 0; l < nl; l++) begin
      x = {1'b0, a >> (l * lw)} & m;
      y = {1'b0, b >> (l * lw)} & m;
      r = sub ? (x + ((~y) & m) + 65'd1) : (x + y);
      s = s | 64'((r & m) << (l * lw));
      c[(l+1)*bpl-1] = r[lw];
    end
    return {c, s};
  endfunction

  function automatic logic [7:0] tops(input logic [1:0] sel);
    logic [7:0] t;
    int         bpl;
    bpl = 1 << sel;
    t   = '0;
    for (int k = bpl - 1; k < 8; k += bpl) t[k] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_pending;
    chk(ptag, sum, exp_sum);
    chk("R7", {56'd0, lane_cout}, {56'd0, exp_cout});
    chk("R8", {56'd0, lane_cout & ~exp_top}, 64'd0);
  endtask

  task automatic step(input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] sel, input logic sub, input string tag);
    logic [71:0] m;
    @(negedge clk);
    if (pend) compare_pending();
    op_a     = a;
    op_b     = b;
    lane_sel = sel;
    sub_en   = sub;
    m        = model(a, b, sel, sub);
    exp_sum  = m[63:0];
    exp_cout = m[71:64];
    exp_top  = tops(sel);
    ptag     = tag;
    pend     = 1'b1;
  endtask

  task automatic flush;
    @(negedge clk);
    if (pend) compare_pending();
    pend = 1'b0;
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 7);
    v = v ^ (v << 17);
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] a;
    logic [63:0] b;

    // R1 at power-up
    repeat (3) @(negedge clk);
    chk("R1", sum, 64'd0);
    chk("R1", {56'd0, lane_cout}, 64'd0);
    rst = 1'b0;

    // R3: the same operands in every mode
    for (int s = 0; s < 4; s++) begin
      step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'(s), 1'b0, "R3");
    end

    // R5: carry ripples across bytes inside wider lanes
    step(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, "R5");
    step(64'h0000_FFFF_00FF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, "R5");
    step(64'h00FF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, "R5");

    // R6 corners: borrow in every lane, and a lane boundary that needs its +1
    for (int s = 0; s < 4; s++) begin
      step(64'd0, 64'h0101_0101_0101_0101, 2'(s), 1'b1, "R6");
      step(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'(s), 1'b1, "R6");
      step(64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 2'(s), 1'b1, "R6");
    end

    // R4: every byte pair in 8-bit add mode, lanes skewed from each other
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int i = 0; i < 8; i++) begin
          a[i*8 +: 8] = 8'(x + i * 29);
          b[i*8 +: 8] = 8'(y ^ (i * 83));
        end
        step(a, b, 2'b00, 1'b0, "R4");
      end
    end

    // R6: strided sweep of 8-bit subtraction
    for (int x = 0; x < 256; x += 3) begin
      for (int y = 0; y < 256; y += 3) begin
        for (int i = 0; i < 8; i++) begin
          a[i*8 +: 8] = 8'(x ^ (i * 53));
          b[i*8 +: 8] = 8'(y + i * 11);
        end
        step(a, b, 2'b00, 1'b1, "R6");
      end
    end

    // Wider modes with pseudo-random operands
    for (int s = 1; s < 4; s++) begin
      for (int n = 0; n < 1500; n++) begin
        rng = next_rng(rng);
        a   = rng;
        rng = next_rng(rng);
        b   = rng;
        step(a, b, 2'(s), n[0], n[0] ? "R6" : "R4");
      end
    end
    flush();

    // R2: output holds until the edge, then shows the new result
    step(64'd5, 64'd7, 2'b11, 1'b0, "R2");
    flush();
    @(negedge clk);
    op_a = 64'd1;
    op_b = 64'd2;
    #1;
    chk("R2", sum, 64'd12);
    @(negedge clk);
    chk("R2", sum, 64'd3);

    // R1 in mid-run
    step(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, "R4");
    flush();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", sum, 64'd0);
    chk("R1", {56'd0, lane_cout}, 64'd0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule